// File: doc/BRIEF.md
# Dual-Colour Matrix Panel Row/Column Receiver

This block models, in synthesizable logic, the receive path of one panel of a cascaded two-colour dot-matrix display. A scan controller feeds one serial bit per colour on each enabled clock edge. Each colour has its own shift chain of `WIDTH` stages. A latch strobe moves the shifted row image onto the column drives. A binary row address picks the single row that is lit. A blanking input turns the whole panel dark while a scan step is set up.

The shift-enable input stands in for the pulses of the panel's shift clock: a rising `clk` edge with `shiftEn` high counts as one shift pulse. The latch is level-sensitive. While `latchIn` is high, the columns follow the shift chain, including any shift made in that cycle. While it is low, the last image is held. Each colour's bit that falls out of the far end of its chain comes out on a serial output. The address, latch, blanking and shift-enable inputs are passed straight through, so a further panel can be chained behind this one.

The block is meant for checking a scan controller in simulation against a faithful model of the panel's logic.

Top module: `panel_rx`

## Requirements
- R1: On a rising `clk` edge with `shiftEn` high, each colour chain moves one place toward index `WIDTH-1` and takes its serial input (`redIn`/`grnIn`) into index 0. After `WIDTH` shifts, the first bit shifted in sits at index `WIDTH-1`. With `shiftEn` low, the chains do not change.
- R2: While `latchIn` is high, `redCol`/`grnCol` equal the current chain contents, including a shift taken on the most recent edge.
- R3: While `latchIn` is low, `redCol`/`grnCol` keep the image from the last edge at which `latchIn` was high, even when the chains shift.
- R4: With `blankIn` low, `rowSel` is one-hot and bit n is set for `rowAddr` = n.
- R5: With `blankIn` high, `rowSel`, `redCol` and `grnCol` are all zero, whatever the latched image.
- R6: On each shift edge, `redOut`/`grnOut` take the value that index `WIDTH-1` held just before that edge. Without a shift they keep their value.
- R7: `addrOut`, `latchOut`, `blankOut` and `shiftOut` follow `rowAddr`, `latchIn`, `blankIn` and `shiftEn` with no clock delay.
- R8: While `rstN` is low, both chains, both held images and both serial outputs are cleared, so no column is lit, even if `latchIn` is high.
- R9: Column bit k is 1 (dot lit) exactly when the image holds a 1 at index k. The red and green images are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edges are shift opportunities |
| rstN | input | 1 | Asynchronous active-low reset |
| shiftEn | input | 1 | Marks a shift pulse on this edge |
| latchIn | input | 1 | High: columns follow the chain; low: hold |
| blankIn | input | 1 | High: all rows and columns off |
| rowAddr | input | ADDR_W (4) | Binary row address |
| redIn | input | 1 | Red serial data, 1 = lit |
| grnIn | input | 1 | Green serial data, 1 = lit |
| redCol | output | WIDTH (32) | Red column drives |
| grnCol | output | WIDTH (32) | Green column drives |
| rowSel | output | ROWS (16) | One-hot row selects |
| redOut | output | 1 | Red bit shifted out, to the next panel |
| grnOut | output | 1 | Green bit shifted out, to the next panel |
| addrOut | output | ADDR_W (4) | Row address passed through |
| latchOut | output | 1 | Latch strobe passed through |
| blankOut | output | 1 | Blanking passed through |
| shiftOut | output | 1 | Shift enable passed through |

## Verification
The decoder is driven from a table of addresses that includes both ends of the range, a few middle rows and a blanked entry. This separates a correct one-hot decode from bit-order slips and from a missing blank gate. Two asymmetric 32-bit images, different for red and green, are shifted in most-significant bit first. This exposes a reversed shift direction, swapped colours and off-by-one serial output timing. A second image is then shifted in with the latch low, which proves the hold and also checks the serial stream carrying the first image toward the next panel. One cycle with the latch high during a shift shows transparency. A reset taken after a loaded image, with the latch held high, shows that nothing stays lit.

// File: rtl/panel_pkg.sv
package panel_pkg;
  // strobes from control to each colour datapath
  typedef struct packed {
    logic shift;  // shift pulse on this edge
    logic load;   // latch transparent
    logic blank;  // force columns dark
  } strobe_t;
endpackage

// File: rtl/panel_ctrl.sv
module panel_ctrl
  import panel_pkg::*;
#(
  parameter int ROWS = 16,
  localparam int ADDR_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              latchIn,
  input  logic              blankIn,
  input  logic [ADDR_W-1:0] rowAddr,
  output strobe_t           strobes,
  output logic [ROWS-1:0]   rowSel
);

  always_comb begin
    strobes.shift = shiftEn;
    strobes.load  = latchIn;
    strobes.blank = blankIn;
  end

  for (genvar g = 0; g < ROWS; g++) begin : gRow
    assign rowSel[g] = !blankIn && (rowAddr == ADDR_W'(g));
  end

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    !blankIn |-> ($countones(rowSel) == 1 && rowSel[rowAddr])); // R4
  AST_ROW_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    blankIn |-> (rowSel == '0)); // R5

endmodule

// File: rtl/panel_chain.sv
module panel_chain
  import panel_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic             serIn,
  output logic             serOut,
  output logic [WIDTH-1:0] cols
);

  logic [WIDTH-1:0] shiftQ, shiftNext, heldQ, image;
  logic             serQ;

  always_comb begin
    shiftNext = strobes.shift ? {shiftQ[WIDTH-2:0], serIn} : shiftQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      serQ   <= 1'b0;
      heldQ  <= '0;
    end else begin
      shiftQ <= shiftNext;
      if (strobes.shift) serQ <= shiftQ[WIDTH-1];
      if (strobes.load) heldQ <= shiftNext;
    end
  end

  // transparent while load is high, held image otherwise
  assign image  = strobes.load ? shiftQ : heldQ;
  assign cols   = strobes.blank ? '0 : image;
  assign serOut = serQ;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> (shiftQ[0] == $past(serIn))); // R1
  AST_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shift |=> $stable(shiftQ)); // R1
  AST_SER_OUT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> (serOut == $past(shiftQ[WIDTH-1]))); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(heldQ)); // R3

endmodule

// File: rtl/panel_rx.sv
module panel_rx
  import panel_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int ROWS  = 16,
  localparam int ADDR_W = $clog2(ROWS),
  localparam int COLORS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              latchIn,
  input  logic              blankIn,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic              redIn,
  input  logic              grnIn,
  output logic [WIDTH-1:0]  redCol,
  output logic [WIDTH-1:0]  grnCol,
  output logic [ROWS-1:0]   rowSel,
  output logic              redOut,
  output logic              grnOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              latchOut,
  output logic              blankOut,
  output logic              shiftOut
);

  strobe_t          strobes;
  logic [COLORS-1:0] serIn, serOut;
  logic [WIDTH-1:0]  colsArr [COLORS];

  panel_ctrl #(.ROWS(ROWS)) uCtrl (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .latchIn(latchIn),
    .blankIn(blankIn), .rowAddr(rowAddr), .strobes(strobes), .rowSel(rowSel)
  );

  assign serIn = {grnIn, redIn};

  for (genvar c = 0; c < COLORS; c++) begin : gColor
    panel_chain #(.WIDTH(WIDTH)) uChain (
      .clk(clk), .rstN(rstN), .strobes(strobes),
      .serIn(serIn[c]), .serOut(serOut[c]), .cols(colsArr[c])
    );
  end

  assign redCol = colsArr[0];
  assign grnCol = colsArr[1];
  assign redOut = serOut[0];
  assign grnOut = serOut[1];

  // pass-through to the next cascaded panel
  assign addrOut  = rowAddr;
  assign latchOut = latchIn;
  assign blankOut = blankIn;
  assign shiftOut = shiftEn;

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rstN)
    blankIn |-> (redCol == '0 && grnCol == '0)); // R5
  AST_RESET_DARK: assert property (@(posedge clk)
    !rstN |-> (redCol == '0 && grnCol == '0 && !redOut && !grnOut)); // R8

endmodule

// File: tb/tb_panel_rx.sv
module tb_panel_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 32;
  localparam int ROWS = 16;
  localparam int ADDR_W = 4;
  localparam int NVEC = 6;
  // {addr, blank, expected rowSel}
  localparam logic [ADDR_W+ROWS:0] VECS [NVEC] = '{
    {4'd0,  1'b0, 16'h0001},
    {4'd15, 1'b0, 16'h8000},
    {4'd5,  1'b0, 16'h0020},
    {4'd10, 1'b0, 16'h0400},
    {4'd3,  1'b1, 16'h0000},
    {4'd9,  1'b0, 16'h0200}
  };
  localparam logic [WIDTH-1:0] PAT_R1 = 32'hA5C3_0F71;
  localparam logic [WIDTH-1:0] PAT_G1 = 32'h1234_FEDC;
  localparam logic [WIDTH-1:0] PAT_R2 = 32'h0FF0_8001;
  localparam logic [WIDTH-1:0] PAT_G2 = 32'hC001_7E3B;

  logic clk = 1'b0, rstN = 1'b0, shiftEn = 1'b0, latchIn = 1'b0, blankIn = 1'b0;
  logic [ADDR_W-1:0] rowAddr = '0;
  logic redIn = 1'b0, grnIn = 1'b0;
  logic [WIDTH-1:0] redCol, grnCol;
  logic [ROWS-1:0] rowSel;
  logic redOut, grnOut, latchOut, blankOut, shiftOut;
  logic [ADDR_W-1:0] addrOut;

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] expR = '0, expG = '0;
  logic expSerR = 1'b0, expSerG = 1'b0;

  panel_rx dut (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .latchIn(latchIn),
    .blankIn(blankIn), .rowAddr(rowAddr), .redIn(redIn), .grnIn(grnIn),
    .redCol(redCol), .grnCol(grnCol), .rowSel(rowSel), .redOut(redOut),
    .grnOut(grnOut), .addrOut(addrOut), .latchOut(latchOut),
    .blankOut(blankOut), .shiftOut(shiftOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one shift pulse; bench model follows R1 and R6
  task automatic shiftOne(input logic r, input logic g);
    redIn = r; grnIn = g; shiftEn = 1'b1;
    tick();
    shiftEn = 1'b0;
    expSerR = expR[WIDTH-1]; expSerG = expG[WIDTH-1];
    expR = {expR[WIDTH-2:0], r}; expG = {expG[WIDTH-2:0], g};
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] heldR, heldG;
    // R8: reset state, latch high yet nothing lit
    latchIn = 1'b1;
    tick(); tick();
    check("R8 red cols in reset", 64'(redCol), 64'h0);
    check("R8 green cols in reset", 64'(grnCol), 64'h0);
    check("R8 serial outs in reset", 64'({redOut, grnOut}), 64'h0);
    latchIn = 1'b0;
    rstN = 1'b1;
    tick();

    // R4/R5/R7: decode table
    for (int i = 0; i < NVEC; i++) begin
      {rowAddr, blankIn} = VECS[i][ADDR_W+ROWS:ROWS];
      #1;
      check("R4/R5 rowSel", 64'(rowSel), 64'(VECS[i][ROWS-1:0]));
      check("R7 pass-through", 64'({addrOut, blankOut}), 64'({rowAddr, blankIn}));
      tick();
    end
    blankIn = 1'b0; rowAddr = 4'd2;

    // R1/R6/R9: shift first image, latch low
    for (int i = 0; i < WIDTH; i++) begin
      shiftOne(PAT_R1[WIDTH-1-i], PAT_G1[WIDTH-1-i]);
      if (i == 0) check("R6 serial after first shift", 64'({redOut, grnOut}), 64'b00);
    end
    check("R3 hold during load (red)", 64'(redCol), 64'h0);
    latchIn = 1'b1; shiftEn = 1'b0;
    #1;
    check("R7 latch/shift pass-through", 64'({latchOut, shiftOut}), 64'b10);
    check("R1/R9 red image", 64'(redCol), 64'(PAT_R1));
    check("R1/R9 green image", 64'(grnCol), 64'(PAT_G1));
    tick();
    latchIn = 1'b0;
    heldR = PAT_R1; heldG = PAT_G1;

    // R5: blank hides image
    blankIn = 1'b1; #1;
    check("R5 blank red", 64'(redCol), 64'h0);
    check("R5 blank green", 64'(grnCol), 64'h0);
    check("R5 blank rows", 64'(rowSel), 64'h0);
    blankIn = 1'b0;

    // R3/R6: second image with latch low; serial carries first image
    for (int i = 0; i < WIDTH; i++) begin
      shiftOne(PAT_R2[WIDTH-1-i], PAT_G2[WIDTH-1-i]);
      check("R6 serial out", 64'({redOut, grnOut}), 64'({expSerR, expSerG}));
      if (i % 8 == 3) check("R3 hold while shifting", 64'({redCol, grnCol}), 64'({heldR, heldG}));
    end
    // R1: no shift without enable
    redIn = 1'b1; grnIn = 1'b1; tick();
    check("R6 serial stable w/o shift", 64'({redOut, grnOut}), 64'({expSerR, expSerG}));
    latchIn = 1'b1; #1;
    check("R1 red unchanged w/o enable", 64'(redCol), 64'(PAT_R2));
    check("R1 green unchanged w/o enable", 64'(grnCol), 64'(PAT_G2));

    // R2: transparency during a shift
    shiftOne(1'b1, 1'b0);
    check("R2 transparent red", 64'(redCol), 64'(expR));
    check("R2 transparent green", 64'(grnCol), 64'(expG));
    latchIn = 1'b0;
    shiftOne(1'b0, 1'b1);
    check("R3 held after latch falls", 64'(redCol), 64'({PAT_R2[WIDTH-2:0], 1'b1}));

    // R8: reset after a loaded image
    latchIn = 1'b1; rstN = 1'b0; #1;
    check("R8 mid-run reset red", 64'(redCol), 64'h0);
    check("R8 mid-run reset green", 64'(grnCol), 64'h0);
    tick();
    rstN = 1'b1; latchIn = 1'b0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule